// File: doc/BRIEF.md
# Timebase Interrupt Slot Controller

The controller turns a 32768 Hz tick into a sixteen-step sequence that repeats once per second. Each step is called a slot and lasts `TICKS_PER_SLOT` clocks. At the end of each slot it raises periodic interrupt requests. A fast stream fires in every slot. A 4 Hz source takes four fixed slots, and a 1 Hz source takes one. A shared 16 Hz stream gets the eleven slots that remain. The block also raises a power-up request, which software cannot mask.

Each source keeps a pending flag. The block picks the highest-priority pending source and drives its 12-bit vector address to a simple CPU, together with an interrupt request. The CPU answers with a one-cycle acknowledge. That acknowledge clears the source currently presented, and the next pending source then appears.

Top module: `tbint_ctrl`

## Requirements
- R1: The slot index advances by one, wrapping from 15 to 0, every `TICKS_PER_SLOT` clocks. The first slot (slot 0) ends on the `TICKS_PER_SLOT`-th rising edge after reset is released, and its flags are visible right after that edge.
- R2: The full-rate 16 Hz source, pending bit 0, is set at the end of every one of the 16 slots.
- R3: The 4 Hz source (bit 2) is set at the end of slots 1, 5, 9 and 13. The 1 Hz source (bit 3) is set at the end of slot 3. The shared 16 Hz source (bit 1) is set at the end of the other 11 slots.
- R4: The vector is 0x3FF for power-up (bit 4), 0x3FE for 1 Hz, 0x3FC for 4 Hz, 0x3F8 for shared 16 Hz and 0x3F1 for full-rate 16 Hz.
- R5: When several flags are pending, the presented source is the highest by fixed priority, in this order: power-up, 1 Hz, 4 Hz, shared 16 Hz, full-rate 16 Hz.
- R6: `irq_ack` high at a rising edge clears only the flag of the presented source. It has no effect when nothing is pending.
- R7: A request for a source that is already pending merges into the existing flag, so a single acknowledge clears it.
- R8: A periodic source whose `src_en` bit (same bit position as its pending bit) is low sets no flag. The slot sequence keeps advancing.
- R9: A high `pwr_up_pulse` at a rising edge sets the power-up flag regardless of `src_en`.
- R10: After reset only the power-up flag is pending, so `irq_req` is 1 and `irq_vector` is 0x3FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz tick clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_up_pulse | input | 1 | Raises the power-up request |
| src_en | input | 4 | Enables for periodic sources: [3] 1 Hz, [2] 4 Hz, [1] shared 16 Hz, [0] full 16 Hz |
| irq_ack | input | 1 | CPU acknowledge of the presented vector |
| irq_req | output | 1 | High while any flag is pending |
| irq_vector | output | 12 | Vector address of the presented source |
| irq_pending | output | 5 | Pending flags: [4] power-up, [3] 1 Hz, [2] 4 Hz, [1] shared 16 Hz, [0] full 16 Hz |

## Verification
The in-line assertions check several properties on every cycle:
- the slot index holds between slot ends and steps by one at each end;
- a disabled source's flag never rises;
- an acknowledge with no new request drops the presented flag;
- a power-up pulse always lands;
- the grant is one-hot, a subset of the pending set, and matches the request line.

Only the bench's scenarios can show the per-second slot share and the exact vector order the CPU receives. They also show the timing of the first slot after reset, the merging of a full second of unacknowledged requests into single flags, and the effect of an acknowledge when nothing is pending.

// File: rtl/tbint_pkg.sv
package tbint_pkg;

    localparam int NUM_SRC      = 5;
    localparam int NUM_PERIODIC = 4;
    localparam int SLOT_W       = 4;
    localparam int VEC_W        = 12;

    typedef enum logic [2:0] {
        SRC_S16 = 3'd0,
        SRC_A16 = 3'd1,
        SRC_F4  = 3'd2,
        SRC_F1  = 3'd3,
        SRC_PWR = 3'd4
    } src_e;

    typedef logic [NUM_SRC-1:0]      src_vec_t;
    typedef logic [NUM_PERIODIC-1:0] per_vec_t;
    typedef logic [SLOT_W-1:0]       slot_t;

    typedef struct packed {
        logic              valid;
        logic [VEC_W-1:0]  addr;
        src_vec_t          grant;
    } pick_t;

    function automatic logic [VEC_W-1:0] vec_of(src_e s);
        logic [VEC_W-1:0] v;
        case (s)
            SRC_PWR: v = 12'h3FF;
            SRC_F1:  v = 12'h3FE;
            SRC_F4:  v = 12'h3FC;
            SRC_A16: v = 12'h3F8;
            default: v = 12'h3F1;
        endcase
        return v;
    endfunction

    // Which periodic sources a finished slot raises.
    function automatic per_vec_t slot_sources(slot_t slot);
        per_vec_t r;
        r = '0;
        r[SRC_S16] = 1'b1;
        if (slot[1:0] == 2'd1)
            r[SRC_F4] = 1'b1;
        else if (slot == slot_t'(3))
            r[SRC_F1] = 1'b1;
        else
            r[SRC_A16] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/tbint_slot_timer.sv
module tbint_slot_timer
    import tbint_pkg::*;
#(
    parameter int TICKS_PER_SLOT = 2048
) (
    input  logic  clk,
    input  logic  rst,
    output logic  slot_end,
    output slot_t slot
);
    localparam int CNT_W = (TICKS_PER_SLOT > 1) ? $clog2(TICKS_PER_SLOT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SLOT - 1);

    logic [CNT_W-1:0] tick_q;
    slot_t            slot_q;

    assign slot_end = (tick_q == LAST);
    assign slot     = slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
            slot_q <= '0;
        end else if (slot_end) begin
            tick_q <= '0;
            slot_q <= slot_q + slot_t'(1);
        end else begin
            tick_q <= tick_q + CNT_W'(1);
        end
    end

    // R1: slot index only moves at a slot end, and then by exactly one
    p_slot_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !slot_end |=> $stable(slot_q));
    p_slot_step_r1: assert property (@(posedge clk) disable iff (rst)
        slot_end |=> slot_q == $past(slot_q) + slot_t'(1));

endmodule

// File: rtl/tbint_pending.sv
module tbint_pending
    import tbint_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     slot_end,
    input  slot_t    slot,
    input  per_vec_t src_en,
    input  logic     pwr_up_pulse,
    input  logic     ack,
    input  src_vec_t grant,
    output src_vec_t pending
);
    per_vec_t raw_req;
    src_vec_t set_vec;
    src_vec_t clr_vec;
    src_vec_t pend_q;

    assign raw_req = slot_end ? slot_sources(slot) : '0;
    assign set_vec = {pwr_up_pulse, raw_req & src_en};
    assign clr_vec = ack ? grant : '0;
    assign pending = pend_q;

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= src_vec_t'(1) << SRC_PWR;
        else
            pend_q <= (pend_q & ~clr_vec) | set_vec;
    end

    for (genvar i = 0; i < NUM_PERIODIC; i++) begin : g_chk
        // R8: a masked source never raises its flag
        p_masked_quiet_r8: assert property (@(posedge clk) disable iff (rst)
            (!src_en[i] && !pend_q[i]) |=> !pend_q[i]);
        // R6: acknowledge drops the presented flag when no new request lands
        p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
            (ack && grant[i] && !(raw_req[i] && src_en[i])) |=> !pend_q[i]);
    end

    // R9: power-up pulse always lands, whatever the enables
    p_pwr_lands_r9: assert property (@(posedge clk) disable iff (rst)
        pwr_up_pulse |=> pend_q[SRC_PWR]);

endmodule

// File: rtl/tbint_arbiter.sv
module tbint_arbiter
    import tbint_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t pending,
    output pick_t    pick
);
    always_comb begin
        pick = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pending[i] && !pick.valid) begin
                pick.valid    = 1'b1;
                pick.grant[i] = 1'b1;
                pick.addr     = vec_of(src_e'(3'(i)));
            end
        end
    end

    // R5: a single granted source, always one that is pending
    p_grant_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pick.grant));
    p_grant_subset_r5: assert property (@(posedge clk) disable iff (rst)
        (pick.grant & ~pending) == '0);
    p_valid_match_r5: assert property (@(posedge clk) disable iff (rst)
        pick.valid == (pending != '0));

endmodule

// File: rtl/tbint_ctrl.sv
module tbint_ctrl
    import tbint_pkg::*;
#(
    parameter int TICKS_PER_SLOT = 2048
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pwr_up_pulse,
    input  logic [3:0]  src_en,
    input  logic        irq_ack,
    output logic        irq_req,
    output logic [11:0] irq_vector,
    output logic [4:0]  irq_pending
);
    logic     slot_end;
    slot_t    slot;
    src_vec_t pend;
    pick_t    pick;

    tbint_slot_timer #(.TICKS_PER_SLOT(TICKS_PER_SLOT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .slot_end (slot_end),
        .slot     (slot)
    );

    tbint_pending u_pend (
        .clk          (clk),
        .rst          (rst),
        .slot_end     (slot_end),
        .slot         (slot),
        .src_en       (src_en),
        .pwr_up_pulse (pwr_up_pulse),
        .ack          (irq_ack),
        .grant        (pick.grant),
        .pending      (pend)
    );

    tbint_arbiter u_arb (
        .clk     (clk),
        .rst     (rst),
        .pending (pend),
        .pick    (pick)
    );

    assign irq_req     = pick.valid;
    assign irq_vector  = pick.addr;
    assign irq_pending = pend;

    // R4: every presented vector lies in the 0x3F0 page
    p_vector_page_r4: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> irq_vector[11:4] == 8'h3F);
    // R10: first cycle out of reset shows the power-up request
    p_reset_pwr_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_pending == 5'b10000 && irq_vector == 12'h3FF));

endmodule

// File: tb/tbint_ctrl_bench.sv
module tbint_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int T          = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_up_pulse = 1'b0;
    logic [3:0]  src_en = 4'b0000;
    logic        cpu_ack = 1'b0;
    logic        man_ack = 1'b0;
    logic        cpu_on  = 1'b0;
    logic        irq_req;
    logic [11:0] irq_vector;
    logic [4:0]  irq_pending;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;
    logic [11:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tbint_ctrl #(.TICKS_PER_SLOT(T)) u_tbint_ctrl (
        .clk          (clk),
        .rst          (rst),
        .pwr_up_pulse (pwr_up_pulse),
        .src_en       (src_en),
        .irq_ack      (cpu_ack | man_ack),
        .irq_req      (irq_req),
        .irq_vector   (irq_vector),
        .irq_pending  (irq_pending)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] slot_vec(input int s);
        if (s == 3)          return 12'h3FE;
        else if (s % 4 == 1) return 12'h3FC;
        else                 return 12'h3F8;
    endfunction

    // driver: expected vectors for one second, optionally with shared stream masked
    task automatic push_second(input bit shared_on);
        for (int s = 0; s < 16; s++) begin
            if (shared_on || slot_vec(s) != 12'h3F8)
                exp_q.push_back(slot_vec(s));
            exp_q.push_back(12'h3F1);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // monitor / simple CPU: takes each request, compares against the queue front
    always begin
        @(negedge clk);
        if (cpu_ack) begin
            cpu_ack = 1'b0;
        end else if (cpu_on && !rst && irq_req) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 R5 unexpected vector", int'(irq_vector), 0);
            end else begin
                logic [11:0] e;
                e = exp_q.pop_front();
                check(irq_vector == e, "R4 R5 vector order", int'(irq_vector), int'(e));
            end
            cpu_ack = 1'b1;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // reset state and first slot timing (R10, R1, R2, R3)
        src_en = 4'b1111;
        do_reset();
        check(irq_pending == 5'b10000, "R10 pending", int'(irq_pending), 'h10);
        check(irq_req == 1'b1, "R10 irq_req", int'(irq_req), 1);
        check(irq_vector == 12'h3FF, "R10 vector", int'(irq_vector), 'h3FF);
        cycles(T - 1);
        check(irq_pending[0] == 1'b0, "R1 before slot end", int'(irq_pending), 'h10);
        cycles(1);
        check(irq_pending == 5'b10011, "R1 R2 R3 slot0 flags", int'(irq_pending), 'h13);
        cycles(T - 1);
        check(irq_pending[2] == 1'b0, "R1 slot1 not yet", int'(irq_pending), 'h13);
        cycles(1);
        check(irq_pending == 5'b10111, "R3 slot1 4Hz", int'(irq_pending), 'h17);

        // full second, all enabled, CPU acks everything (R2 R3 R4 R5)
        exp_q.delete();
        exp_q.push_back(12'h3FF);
        push_second(1'b1);
        cpu_on = 1'b1;
        do_reset();
        cycles(16 * T + 8);
        check(exp_q.size() == 0, "R2 R3 second drained", exp_q.size(), 0);

        // shared stream masked (R8)
        cpu_on = 1'b0;
        src_en = 4'b1101;
        exp_q.delete();
        exp_q.push_back(12'h3FF);
        push_second(1'b0);
        do_reset();
        cpu_on = 1'b1;
        cycles(16 * T + 8);
        check(exp_q.size() == 0, "R8 masked second drained", exp_q.size(), 0);

        // a whole second unacknowledged merges into single flags (R7 R5)
        cpu_on = 1'b0;
        src_en = 4'b1111;
        exp_q.delete();
        do_reset();
        cycles(16 * T + 2);
        check(irq_pending == 5'b11111, "R7 all pending", int'(irq_pending), 'h1F);
        exp_q.push_back(12'h3FF);
        exp_q.push_back(12'h3FE);
        exp_q.push_back(12'h3FC);
        exp_q.push_back(12'h3F8);
        exp_q.push_back(12'h3F1);
        cpu_on = 1'b1;
        cycles(12);
        cpu_on = 1'b0;
        cycles(2);
        check(irq_pending == 5'b00000, "R7 merged cleared", int'(irq_pending), 0);
        check(exp_q.size() == 0, "R5 priority drained", exp_q.size(), 0);

        // power-up pulse and idle acknowledge with everything masked (R9 R6 R8)
        src_en = 4'b0000;
        do_reset();
        man_ack = 1'b1;
        cycles(1);
        man_ack = 1'b0;
        check(irq_pending == 5'b00000, "R6 ack clears pwr", int'(irq_pending), 0);
        man_ack = 1'b1;
        cycles(1);
        man_ack = 1'b0;
        check(irq_pending == 5'b00000 && irq_req == 1'b0, "R6 idle ack",
              int'(irq_pending), 0);
        pwr_up_pulse = 1'b1;
        cycles(1);
        pwr_up_pulse = 1'b0;
        check(irq_pending == 5'b10000, "R9 pulse pending", int'(irq_pending), 'h10);
        check(irq_vector == 12'h3FF, "R9 R4 pulse vector", int'(irq_vector), 'h3FF);
        cycles(16 * T + 4);
        check(irq_pending == 5'b10000, "R8 masked no flags", int'(irq_pending), 'h10);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule